// File: doc/BRIEF.md
# Ordered Replicated Worker Pool

This block raises the throughput of a stateless per-request operation by running several copies of it side by side. Each copy (worker) may spend a different, variable number of cycles on each request, so results can finish in any order. Order is restored by reserving a place for every request in an output reorder buffer at the moment it is accepted, before the request is handed to a worker. The worker carries that slot number with it and deposits its result there when done. Results then leave the buffer strictly in the order the requests arrived.

Requests enter through a valid/ready handshake together with a per-request delay value that programs how long the behavioural worker stand-in takes. A free-worker scheduler picks the lowest-numbered idle worker. A round-robin arbiter admits at most one finished result per cycle into the buffer. A worker that loses arbitration keeps its result until it wins. Results leave through a second valid/ready handshake. The stand-in operation computes three times the operand plus one, modulo 2^16.

Top module: `ordered_pool`

## Requirements
- R1: After reset, outValid is 0 and inReady is 1.
- R2: Every accepted request yields exactly one output, whose value is (3*inData + 1) mod 65536. Outputs appear in the same order the requests were accepted, whatever their delays and whatever the output back-pressure.
- R3: While all four workers hold a request whose result has not yet been written into the buffer, inReady is 0.
- R4: While eight requests are outstanding (accepted but not yet taken at the output), inReady is 0, and the oldest completed result stays presented.
- R5: The oldest outstanding request's result is not presented before that request itself completes, even if younger requests have already completed.
- R6: While outValid is 1 and outReady is 0, outValid stays 1 and outData keeps its value on the next cycle.
- R7: At most one worker result enters the buffer per cycle, and only from a worker that has one pending. A pending result is never lost. When several are pending, one of them is admitted each cycle, in round-robin order. Results that finish in the same cycle are all delivered.
- R8: With the pool idle and empty, a request accepted with delay value d raises outValid exactly d+1 clock edges after the edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request offered |
| inReady | output | 1 | Request can be taken this cycle |
| inData | input | 16 | Request operand |
| inDelay | input | 5 | Extra processing cycles for this request |
| outValid | output | 1 | Oldest result is ready |
| outReady | input | 1 | Consumer takes the presented result |
| outData | output | 16 | Oldest result value |

## Verification
Some properties are checked on every cycle. A presented result holds still under back-pressure. The arbiter grants at most one worker, only one that is requesting, and always one when any is requesting. A worker that is not granted keeps its request. Input is refused when every worker is busy or the buffer is full. Stream order, the arithmetic result and the exact latency only show up in the bench's scenarios. These sweep delay patterns that force reordering, apply intermittent output stalls, finish all four workers in one cycle, and fill the buffer behind a stalled consumer.

// File: rtl/pool_pkg.sv
package pool_pkg;
  localparam int NUM_WORKERS = 4;
  localparam int ROB_DEPTH   = 8;   // power of two: pointers wrap naturally
  localparam int DATA_W      = 16;
  localparam int DLY_W       = 5;

  localparam int WID_W = (NUM_WORKERS > 1) ? $clog2(NUM_WORKERS) : 1;
  localparam int PTR_W = $clog2(ROB_DEPTH);
  localparam int CNT_W = PTR_W + 1;

  // strobes from control to the result storage
  typedef struct packed {
    logic             wrEn;
    logic [WID_W-1:0] wrSrc;
    logic [PTR_W-1:0] wrSlot;
    logic [PTR_W-1:0] rdSlot;
  } robStrb_t;

  // the stateless operation the workers stand in for
  function automatic logic [DATA_W-1:0] streamOp(input logic [DATA_W-1:0] x);
    logic [DATA_W+1:0] t;
    t = {2'b00, x} + {1'b0, x, 1'b0} + (DATA_W+2)'(1);
    return t[DATA_W-1:0];
  endfunction
endpackage

// File: rtl/pool_worker.sv
module pool_worker
  import pool_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] startData,
  input  logic [DLY_W-1:0]  startDelay,
  input  logic [PTR_W-1:0]  startSlot,
  input  logic              grant,
  output logic              busy,
  output logic              wrReq,
  output logic [DATA_W-1:0] resData,
  output logic [PTR_W-1:0]  resSlot
);
  logic [DLY_W-1:0]  remain;
  logic [DATA_W-1:0] operand;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      remain  <= '0;
      operand <= '0;
      resSlot <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      remain  <= startDelay;
      operand <= startData;
      resSlot <= startSlot;
    end else if (grant) begin
      busy <= 1'b0;
    end else if (busy && remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign wrReq   = busy && (remain == '0);
  assign resData = streamOp(operand);
endmodule

// File: rtl/pool_ctrl.sv
module pool_ctrl
  import pool_pkg::*;
(
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               inValid,
  input  logic                               outReady,
  input  logic [NUM_WORKERS-1:0]             busyVec,
  input  logic [NUM_WORKERS-1:0]             reqVec,
  input  logic [NUM_WORKERS-1:0][PTR_W-1:0]  slotVec,
  output logic                               inReady,
  output logic                               outValid,
  output logic [NUM_WORKERS-1:0]             startVec,
  output logic [PTR_W-1:0]                   allocSlot,
  output logic [NUM_WORKERS-1:0]             grantVec,
  output robStrb_t                           strb,
  output logic [CNT_W-1:0]                   robCount
);
  logic [PTR_W-1:0]     headPtr, tailPtr;
  logic [CNT_W-1:0]     countQ;
  logic [ROB_DEPTH-1:0] doneQ;
  logic [WID_W-1:0]     lastGrant;

  logic             anyFree, robFull, accept, pop, anyGrant;
  logic [WID_W-1:0] freeIdx, grantIdx;

  // free-worker scheduler: lowest index wins
  always_comb begin
    anyFree = 1'b0;
    freeIdx = '0;
    for (int i = NUM_WORKERS - 1; i >= 0; i--) begin
      if (!busyVec[i]) begin
        anyFree = 1'b1;
        freeIdx = WID_W'(i);
      end
    end
  end

  // round-robin write-port arbiter, search starts after last winner
  always_comb begin
    int idx;
    anyGrant = 1'b0;
    grantIdx = lastGrant;
    for (int k = 1; k <= NUM_WORKERS; k++) begin
      idx = (int'(lastGrant) + k) % NUM_WORKERS;
      if (!anyGrant && reqVec[idx]) begin
        anyGrant = 1'b1;
        grantIdx = WID_W'(idx);
      end
    end
  end

  assign robFull  = (countQ == CNT_W'(ROB_DEPTH));
  assign inReady  = anyFree && !robFull;
  assign accept   = inValid && inReady;
  assign outValid = (countQ != '0) && doneQ[headPtr];
  assign pop      = outValid && outReady;

  assign startVec  = accept   ? (NUM_WORKERS'(1) << freeIdx)  : '0;
  assign grantVec  = anyGrant ? (NUM_WORKERS'(1) << grantIdx) : '0;
  assign allocSlot = tailPtr;
  assign robCount  = countQ;

  always_comb begin
    strb.wrEn   = anyGrant;
    strb.wrSrc  = grantIdx;
    strb.wrSlot = slotVec[grantIdx];
    strb.rdSlot = headPtr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr   <= '0;
      tailPtr   <= '0;
      countQ    <= '0;
      doneQ     <= '0;
      lastGrant <= WID_W'(NUM_WORKERS - 1);
    end else begin
      if (accept) begin
        tailPtr        <= tailPtr + 1'b1;
        doneQ[tailPtr] <= 1'b0;
      end
      if (pop) begin
        headPtr        <= headPtr + 1'b1;
        doneQ[headPtr] <= 1'b0;
      end
      if (anyGrant) begin
        doneQ[slotVec[grantIdx]] <= 1'b1;
        lastGrant                <= grantIdx;
      end
      case ({accept, pop})
        2'b10:   countQ <= countQ + 1'b1;
        2'b01:   countQ <= countQ - 1'b1;
        default: countQ <= countQ;
      endcase
    end
  end
endmodule

// File: rtl/pool_data.sv
module pool_data
  import pool_pkg::*;
(
  input  logic                               clk,
  input  robStrb_t                           strb,
  input  logic [NUM_WORKERS-1:0][DATA_W-1:0] resVec,
  output logic [DATA_W-1:0]                  outData
);
  logic [DATA_W-1:0] store [ROB_DEPTH];

  always_ff @(posedge clk) begin
    if (strb.wrEn) store[strb.wrSlot] <= resVec[strb.wrSrc];
  end

  assign outData = store[strb.rdSlot];
endmodule

// File: rtl/ordered_pool.sv
module ordered_pool
  import pool_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  input  logic [DLY_W-1:0]  inDelay,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData
);
  logic [NUM_WORKERS-1:0]             busyVec, reqVec, startVec, grantVec;
  logic [NUM_WORKERS-1:0][PTR_W-1:0]  slotVec;
  logic [NUM_WORKERS-1:0][DATA_W-1:0] resVec;
  logic [PTR_W-1:0]                   allocSlot;
  logic [CNT_W-1:0]                   robCount;
  robStrb_t                           strb;

  pool_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .busyVec(busyVec), .reqVec(reqVec), .slotVec(slotVec),
    .inReady(inReady), .outValid(outValid), .startVec(startVec),
    .allocSlot(allocSlot), .grantVec(grantVec), .strb(strb),
    .robCount(robCount)
  );

  pool_data u_data (
    .clk(clk), .strb(strb), .resVec(resVec), .outData(outData)
  );

  for (genvar w = 0; w < NUM_WORKERS; w++) begin : g_worker
    pool_worker u_worker (
      .clk(clk), .rstN(rstN), .start(startVec[w]),
      .startData(inData), .startDelay(inDelay), .startSlot(allocSlot),
      .grant(grantVec[w]), .busy(busyVec[w]), .wrReq(reqVec[w]),
      .resData(resVec[w]), .resSlot(slotVec[w])
    );
  end
endmodule

// File: rtl/ordered_pool_chk.sv
module ordered_pool_chk
  import pool_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   inReady,
  input logic                   outValid,
  input logic                   outReady,
  input logic [DATA_W-1:0]      outData,
  input logic [NUM_WORKERS-1:0] busyVec,
  input logic [NUM_WORKERS-1:0] reqVec,
  input logic [NUM_WORKERS-1:0] grantVec,
  input logic [CNT_W-1:0]       robCount
);
  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R7
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec));

  // R7
  grant_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grantVec & ~reqVec) == '0);

  // R7
  grant_any_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|reqVec) |-> (|grantVec));

  // R7
  pending_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(reqVec & ~grantVec)) |=>
      ((reqVec & $past(reqVec & ~grantVec)) == $past(reqVec & ~grantVec)));

  // R3
  all_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (&busyVec) |-> !inReady);

  // R4
  rob_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (robCount == CNT_W'(ROB_DEPTH)) |-> !inReady);

  // R4
  rob_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    robCount <= CNT_W'(ROB_DEPTH));
endmodule

bind ordered_pool ordered_pool_chk u_chk (
  .clk(clk), .rstN(rstN), .inReady(inReady), .outValid(outValid),
  .outReady(outReady), .outData(outData), .busyVec(busyVec),
  .reqVec(reqVec), .grantVec(grantVec), .robCount(robCount)
);

// File: tb/ordered_pool_test.sv
`timescale 1ns/1ps
module ordered_pool_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic        inReady;
  logic [15:0] inData;
  logic [4:0]  inDelay;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [15:0] outData;

  int nChecks = 0;
  int nFail   = 0;
  int wrIdx   = 0;
  int rdIdx   = 0;
  int cyc     = 0;
  bit sinkEn    = 1'b0;
  bit stallMode = 1'b0;
  logic [15:0] expQ [512];

  always #2 clk = ~clk;   // 250 MHz

  ordered_pool uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inDelay(inDelay), .outValid(outValid),
    .outReady(outReady), .outData(outData)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endtask

  function automatic logic [15:0] refOp(input logic [15:0] x);
    int v;
    v = (int'(x) * 3 + 1) % 65536;
    return v[15:0];
  endfunction

  // output consumer drive: changes only on the falling edge
  always @(negedge clk) begin
    cyc++;
    outReady = sinkEn && !(stallMode && (cyc % 3 == 0));
  end

  // output monitor: samples one ns before the rising edge
  always begin
    @(negedge clk);
    #1;
    if (outValid && outReady) begin
      if (rdIdx >= wrIdx) chk("R2 extra output", rdIdx, wrIdx - 1);
      else chk("R2 value/order", int'(outData), int'(expQ[rdIdx % 512]));
      rdIdx++;
    end
  end

  task automatic send(input logic [15:0] d, input logic [4:0] dl);
    inValid = 1'b1;
    inData  = d;
    inDelay = dl;
    while (!inReady) @(negedge clk);
    @(posedge clk);
    expQ[wrIdx % 512] = refOp(d);
    wrIdx++;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic drain();
    sinkEn = 1'b1;
    while (rdIdx != wrIdx) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL R2 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    int n;
    logic [15:0] held;
    int base;
    inValid = 1'b0;
    inData  = '0;
    inDelay = '0;
    rstN    = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 outValid", int'(outValid), 0);
    chk("R1 inReady", int'(inReady), 1);

    // R8 latency from an idle pool for every small delay
    sinkEn = 1'b1;
    for (int d = 0; d < 7; d++) begin
      send(16'(100 + d), 5'(d));
      n = 0;
      while (!outValid && n < 100) begin
        @(posedge clk);
        n++;
        @(negedge clk);
      end
      chk("R8 latency edges", n, d + 1);
      drain();
    end

    // R5 younger result done first, head must wait
    send(16'd7001, 5'd25);
    send(16'd7002, 5'd0);
    repeat (10) @(negedge clk);
    chk("R5 head not ready", int'(outValid), 0);
    drain();

    // R3 all workers busy
    for (int i = 0; i < 4; i++) send(16'(300 + i), 5'd30);
    chk("R3 inReady all busy", int'(inReady), 0);
    drain();

    // R7 four results finish in the same cycle
    base = rdIdx;
    send(16'd501, 5'd3);
    send(16'd502, 5'd2);
    send(16'd503, 5'd1);
    send(16'd504, 5'd0);
    drain();
    chk("R7 simultaneous all delivered", rdIdx - base, 4);

    // R4 / R6 fill the buffer behind a stalled consumer
    sinkEn = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++) send(16'(60000 + i * 777), 5'(i % 3));
    repeat (20) @(negedge clk);
    chk("R4 inReady when full", int'(inReady), 0);
    chk("R4 head presented", int'(outValid), 1);
    chk("R4 head value", int'(outData), int'(expQ[rdIdx % 512]));
    held = outData;
    repeat (3) @(negedge clk);
    chk("R6 outData held", int'(outData), int'(held));
    chk("R6 outValid held", int'(outValid), 1);
    drain();

    // R2 sweep of delay patterns with and without output stalls
    for (int k = 1; k <= 7; k++) begin
      stallMode = k[0];
      for (int i = 0; i < 10; i++) begin
        if (k == 7) send(16'(k * 4000 + i * 13), 5'((9 - i) * 3));
        else        send(16'(k * 4000 + i * 13), 5'((i * k + k) % 11));
      end
      drain();
    end
    stallMode = 1'b0;

    chk("R2 every request answered", rdIdx, wrIdx);
    summary();
    $finish;
  end
endmodule